// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers single-cycle event pulses from a network controller's datapath into one interrupt line. Each event pulse sets a sticky bit in a cause register. A mask selects which pending causes may raise the line. Software changes the mask only by writing to two registers. One register turns bits on and the other turns bits off, so no read-modify-write is needed and two agents cannot overwrite each other's settings. Pending causes are cleared with write-one-to-clear writes to the cause register.

A throttle register sets a minimum gap between two assertions of the interrupt line. The gap is counted in units of 256 ns. The parameter `UNIT_CYC` gives the number of clock cycles in one unit. A throttle value of zero turns throttling off. Once the line is asserted, it stays high for as long as an enabled cause is pending. The throttle only delays a new assertion.

The register port is a plain single-cycle port: a write strobe, an address and write data. Read data depends combinationally on the address.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, the cause register, the mask and the throttle value all read 0, and `irq_o` is low.
- R2: An event pulse on an implemented position sets that cause bit, and the bit stays set until software clears it. The implemented positions are 0, 1, 2, 3, 4, 6, 7, 9, 10, 12, 15 and 16. Pulses on positions 5, 8, 11, 13 and 14 are ignored, and those cause bits always read 0.
- R3: A write to the cause register at offset 0x0C0 clears every cause bit that is written as 1. Bits written as 0 keep their value. Writing all ones clears every cause.
- R4: If an event pulse arrives in the same cycle as a clearing write to its cause bit, the bit stays set.
- R5: A write to offset 0x0D0 enables every implemented cause written as 1 and leaves the other mask bits unchanged. A read of 0x0D0 returns the current mask. Mask bits at unimplemented positions read 0.
- R6: A write to offset 0x0D8 disables every cause written as 1 and leaves the other mask bits unchanged. A read of 0x0D8 returns 0.
- R7: `irq_o` is high only when (cause AND mask) is nonzero. It responds in the same cycle that the cause or the mask register changes. A cause register that reads 0 always comes with a low `irq_o`.
- R8: The throttle value is 16 bits wide at offset 0x0C4 and reads back as written. With a value of 0, a newly pending enabled cause raises `irq_o` in the cycle after the event edge.
- R9: With a throttle value N greater than 0, `irq_o` rises again no earlier than 1 + N*UNIT_CYC clock edges after the edge on which it last rose. In the meantime `irq_o` stays high as long as an enabled cause is pending.
- R10: A read of offset 0x0C0 returns the latched causes, including causes whose mask bit is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`; 0 at unused offsets |
| evt_in | input | CAUSE_W | Event pulses, one bit per cause position |
| irq_o | output | 1 | Interrupt request, high level while asserted |

## Verification
A cause flop that loses its bit shows up at the next read of 0x0C0. It also drops `irq_o` in the same cycle if that cause is enabled. A bad mask bit shows up at once on a readback of 0x0D0, and on `irq_o` as soon as a matching event arrives. A bad load of the throttle counter or a bad prescaler only shows up when the line rises again. The bench therefore measures, for several throttle values, the exact number of clock edges between two rises. An off-by-one error in either counter changes that count by 1 or by UNIT_CYC.

// File: rtl/icm_pkg.sv
// Package: register offsets and the set of implemented cause positions
// shared by the interrupt cause/mask controller and its checker.
package icm_pkg;
    // Register byte offsets decoded by the register port.
    localparam int unsigned OFF_CAUSE    = 32'h0C0;
    localparam int unsigned OFF_THROTTLE = 32'h0C4;
    localparam int unsigned OFF_MASK_SET = 32'h0D0;
    localparam int unsigned OFF_MASK_CLR = 32'h0D8;

    // Cause positions that exist; every other position is tied off.
    localparam logic [31:0] CAUSE_IMPL = 32'h0001_96DF;

    // Named cause positions.
    localparam int unsigned C_TX_WB      = 0;
    localparam int unsigned C_TX_EMPTY   = 1;
    localparam int unsigned C_LINK_CHG   = 2;
    localparam int unsigned C_RX_SEQ     = 3;
    localparam int unsigned C_RX_MINTHR  = 4;
    localparam int unsigned C_RX_OVERRUN = 6;
    localparam int unsigned C_RX_TIMER   = 7;
    localparam int unsigned C_MDIO_DONE  = 9;
    localparam int unsigned C_RX_CFG     = 10;
    localparam int unsigned C_PHY        = 12;
    localparam int unsigned C_TX_LOW     = 15;
    localparam int unsigned C_RX_SMALL   = 16;
endpackage

// File: rtl/icm_cause_latch.sv
// Sticky cause register. Each implemented bit is set by an event pulse
// and cleared by a clear request. If both arrive in the same cycle, the
// set wins. Assumes events are single-cycle pulses in the clk domain.
module icm_cause_latch #(
    parameter int unsigned CAUSE_W = 17,
    parameter logic [31:0] IMPL    = 32'h0001_96DF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] evt,
    input  logic [CAUSE_W-1:0] clr,
    output logic [CAUSE_W-1:0] cause_q
);
    localparam logic [CAUSE_W-1:0] IMPL_C = IMPL[CAUSE_W-1:0];

    logic unused_bits;
    assign unused_bits = ^{evt & ~IMPL_C, clr & ~IMPL_C};

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
        if (IMPL_C[i]) begin : g_impl
            // Per-bit sticky flop: a new event has priority over clearing.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cause_q[i] <= 1'b0;
                else
                    cause_q[i] <= evt[i] | (cause_q[i] & ~clr[i]);
            end
        end else begin : g_tie
            assign cause_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/icm_regs.sv
// Register decode: the mask (changed only by set and clear writes), the
// throttle value, the cause clear request and the read mux. Assumes a
// single-cycle write strobe and reads that depend only on the address.
module icm_regs
    import icm_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CAUSE_W = 17,
    parameter int unsigned THR_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CAUSE_W-1:0] cause_q,
    output logic [CAUSE_W-1:0] mask_q,
    output logic [THR_W-1:0]   interval_q,
    output logic [CAUSE_W-1:0] cause_clr,
    output logic [DATA_W-1:0]  rdata
);
    localparam logic [CAUSE_W-1:0] IMPL_C = CAUSE_IMPL[CAUSE_W-1:0];

    logic hit_cause, hit_thr, hit_set, hit_clr;
    logic unused_hi;

    assign hit_cause = (addr == ADDR_W'(OFF_CAUSE));
    assign hit_thr   = (addr == ADDR_W'(OFF_THROTTLE));
    assign hit_set   = (addr == ADDR_W'(OFF_MASK_SET));
    assign hit_clr   = (addr == ADDR_W'(OFF_MASK_CLR));
    assign unused_hi = ^wdata[DATA_W-1:CAUSE_W];

    // Write-one-to-clear request for the cause latch.
    assign cause_clr = (we && hit_cause) ? wdata[CAUSE_W-1:0] : '0;

    // Mask register: set-only and clear-only write paths.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (we && hit_set)
            mask_q <= mask_q | (wdata[CAUSE_W-1:0] & IMPL_C);
        else if (we && hit_clr)
            mask_q <= mask_q & ~wdata[CAUSE_W-1:0];
    end

    // Throttle value register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            interval_q <= '0;
        else if (we && hit_thr)
            interval_q <= wdata[THR_W-1:0];
    end

    // Read mux; offsets with nothing to read (incl. mask clear) give 0.
    always_comb begin
        rdata = '0;
        if (hit_cause)
            rdata = DATA_W'(cause_q);
        else if (hit_thr)
            rdata = DATA_W'(interval_q);
        else if (hit_set)
            rdata = DATA_W'(mask_q);
    end
endmodule

// File: rtl/icm_throttle.sv
// Interrupt gate with a minimum gap between rises. A rise loads the gap
// counter with the throttle value, and the counter counts down once per
// UNIT_CYC cycles. A new rise is allowed only when the counter is at 0.
// A line that is already high stays high while a cause is pending.
module icm_throttle #(
    parameter int unsigned THR_W    = 16,
    parameter int unsigned UNIT_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pending,
    input  logic [THR_W-1:0] interval,
    output logic             irq,
    output logic             active_q,
    output logic [THR_W-1:0] cnt_q
);
    localparam int unsigned PRE_W = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_CYC - 1);

    logic [PRE_W-1:0] pre_q;
    logic             gate_open, rise;

    assign gate_open = (cnt_q == '0);
    assign irq       = pending && (active_q || gate_open);
    assign rise      = irq && !active_q;

    // Track the line level, reload on a rise, then count down per unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            pre_q    <= '0;
        end else begin
            active_q <= irq;
            if (rise) begin
                cnt_q <= interval;
                pre_q <= '0;
            end else if (cnt_q != '0) begin
                if (pre_q == PRE_LAST) begin
                    pre_q <= '0;
                    cnt_q <= cnt_q - 1'b1;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end else begin
                pre_q <= '0;
            end
        end
    end
endmodule

// File: rtl/irq_cause_ctrl.sv
// Top level of the interrupt cause/mask controller. Event pulses set
// sticky causes, and the mask selects which causes may drive irq_o. A
// throttle sets the minimum gap between rises, counted in 256 ns units
// of UNIT_CYC clock cycles each. Assumes a single-cycle register port.
module irq_cause_ctrl
    import icm_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CAUSE_W  = 17,
    parameter int unsigned THR_W    = 16,
    parameter int unsigned UNIT_CYC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [CAUSE_W-1:0] evt_in,
    output logic               irq_o
);
    logic [CAUSE_W-1:0] cause_q, mask_q, cause_clr;
    logic [THR_W-1:0]   interval_q, cnt_q;
    logic               active_q, pending;

    // Register decode, mask and throttle value.
    icm_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W), .THR_W(THR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .cause_q(cause_q), .mask_q(mask_q),
        .interval_q(interval_q), .cause_clr(cause_clr), .rdata(reg_rdata)
    );

    // Sticky cause bits.
    icm_cause_latch #(
        .CAUSE_W(CAUSE_W), .IMPL(CAUSE_IMPL)
    ) u_cause (
        .clk(clk), .rst_n(rst_n), .evt(evt_in), .clr(cause_clr),
        .cause_q(cause_q)
    );

    // Any enabled cause pending.
    assign pending = |(cause_q & mask_q);

    // Rate-limited interrupt gate.
    icm_throttle #(
        .THR_W(THR_W), .UNIT_CYC(UNIT_CYC)
    ) u_thr (
        .clk(clk), .rst_n(rst_n), .pending(pending), .interval(interval_q),
        .irq(irq_o), .active_q(active_q), .cnt_q(cnt_q)
    );
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
// Checker for irq_cause_ctrl. It is attached by bind and watches the
// ports and the registers that the submodules drive.
module irq_cause_ctrl_chk
    import icm_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CAUSE_W = 17,
    parameter int unsigned THR_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [CAUSE_W-1:0] evt_in,
    input logic               irq_o,
    input logic [CAUSE_W-1:0] cause_q,
    input logic [CAUSE_W-1:0] mask_q,
    input logic [THR_W-1:0]   cnt_q,
    input logic [THR_W-1:0]   interval_q,
    input logic               active_q
);
    localparam logic [CAUSE_W-1:0] IMPL_C = CAUSE_IMPL[CAUSE_W-1:0];

    // R7
    no_enabled_cause_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q & mask_q) == '0) |-> !irq_o);

    // R2
    unimpl_cause_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q & ~IMPL_C) == '0));

    // R4
    event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_in & IMPL_C)) |=>
        ((cause_q & $past(evt_in & IMPL_C)) == $past(evt_in & IMPL_C)));

    // R3
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFF_CAUSE) && evt_in == '0) |=>
        ((cause_q & $past(reg_wdata[CAUSE_W-1:0])) == '0));

    // R5
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFF_MASK_SET)) |=>
        ((mask_q & $past(reg_wdata[CAUSE_W-1:0] & IMPL_C)) ==
         $past(reg_wdata[CAUSE_W-1:0] & IMPL_C)));

    // R6
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFF_MASK_CLR)) |=>
        ((mask_q & $past(reg_wdata[CAUSE_W-1:0])) == '0));

    // R9
    rise_loads_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !active_q) |=> (cnt_q == $past(interval_q)));
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W), .THR_W(THR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt_in(evt_in), .irq_o(irq_o),
    .cause_q(cause_q), .mask_q(mask_q), .cnt_q(cnt_q),
    .interval_q(interval_q), .active_q(active_q)
);

// File: tb/sim_irq_cause_ctrl.sv
module sim_irq_cause_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int CW     = 17;
    localparam int UNIT   = 4;
    localparam logic [31:0] IMPL = 32'h0001_96DF; // R2 positions
    localparam logic [ADDR_W-1:0] A_CAUSE = 12'h0C0;
    localparam logic [ADDR_W-1:0] A_THR   = 12'h0C4;
    localparam logic [ADDR_W-1:0] A_SET   = 12'h0D0;
    localparam logic [ADDR_W-1:0] A_CLR   = 12'h0D8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [CW-1:0]     evt_in = '0;
    logic              irq_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    irq_cause_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAUSE_W(CW), .THR_W(16), .UNIT_CYC(UNIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [CW-1:0] e);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] m;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(A_CAUSE, v); check("R1 cause", v, 0);
        rd(A_SET, v);   check("R1 mask", v, 0);
        rd(A_THR, v);   check("R1 throttle", v, 0);
        check("R1 irq", {31'd0, irq_o}, 0);

        // R2/R10/R3/R7: each position, mask off
        for (int b = 0; b < CW; b++) begin
            pulse(CW'(1) << b);
            idle(2);
            rd(A_CAUSE, v);
            check($sformatf("R2 R10 bit %0d", b), v, IMPL & (32'd1 << b));
            check($sformatf("R7 masked irq bit %0d", b), {31'd0, irq_o}, 0);
            wr(A_CAUSE, 32'hFFFF_FFFF);
            rd(A_CAUSE, v);
            check($sformatf("R3 clear-all bit %0d", b), v, 0);
            check("R7 cause zero irq low", {31'd0, irq_o}, 0);
        end

        // R3 partial clear
        pulse(CW'(5));
        wr(A_CAUSE, 32'h1);
        rd(A_CAUSE, v); check("R3 partial clear", v, 32'h4);
        wr(A_CAUSE, 32'hFFFF_FFFF);

        // R4 event concurrent with clear-all
        pulse(CW'(1));
        evt_in = CW'(1) << 7;
        wr(A_CAUSE, 32'hFFFF_FFFF);
        evt_in = '0;
        rd(A_CAUSE, v); check("R4 set wins over clear", v, 32'h80);
        wr(A_CAUSE, 32'hFFFF_FFFF);

        // R5/R6 sweep of set and clear per position
        m = 0;
        for (int b = 0; b < 32; b++) begin
            wr(A_SET, 32'd1 << b);
            m = m | ((32'd1 << b) & IMPL);
            rd(A_SET, v); check($sformatf("R5 set bit %0d", b), v, m);
        end
        rd(A_CLR, v); check("R6 clear reads zero", v, 0);
        for (int b = 0; b < CW; b += 2) begin
            wr(A_CLR, 32'd1 << b);
            m = m & ~(32'd1 << b);
            rd(A_SET, v); check($sformatf("R6 clear bit %0d", b), v, m);
        end
        wr(A_SET, 32'h0);
        rd(A_SET, v); check("R5 zero write no change", v, m);
        wr(A_CLR, 32'hFFFF_FFFF);

        // R7: masked pending cause, then enable, then disable
        pulse(CW'(1) << 9);
        check("R7 disabled cause irq", {31'd0, irq_o}, 0);
        wr(A_SET, 32'd1 << 9);
        check("R7 irq on mask set", {31'd0, irq_o}, 1);
        wr(A_CLR, 32'd1 << 9);
        check("R7 irq off on mask clear", {31'd0, irq_o}, 0);
        wr(A_CAUSE, 32'hFFFF_FFFF);

        // R8/R9 throttle sweep
        wr(A_SET, 32'd1 << 2);
        for (int n = 0; n <= 3; n++) begin
            int r;
            int lim;
            wr(A_THR, 32'(n));
            rd(A_THR, v); check($sformatf("R8 readback %0d", n), v, 32'(n));
            idle(UNIT * 4 + 4);
            pulse(CW'(1) << 2);
            check($sformatf("R8 R9 first rise n=%0d", n), {31'd0, irq_o}, 1);
            r = cyc;
            if (n > 0) begin
                idle(1);
                check("R9 held while pending", {31'd0, irq_o}, 1);
                r = r - 1;
                r = r + 1;
            end
            wr(A_CAUSE, 32'hFFFF_FFFF);
            pulse(CW'(1) << 2);
            lim = 0;
            while (irq_o !== 1'b1 && lim < 100) begin
                @(negedge clk);
                lim++;
            end
            if (n == 0) begin
                // with a hold idle skipped, rise is 2 edges later
                check("R8 no throttle gap", 32'(cyc - r), 32'd2);
            end else begin
                // held one extra edge before the clear
                check($sformatf("R9 gap n=%0d", n), 32'(cyc - r), 32'(1 + n * UNIT));
            end
            wr(A_CAUSE, 32'hFFFF_FFFF);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule